// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog whose whole state is held in one 32-bit control word that software writes and reads back. Once enabled it counts ticks of a prescaled reference clock towards a timeout that software picks from four lengths. When the timeout first runs out, the block raises an interrupt flag and then gives software a fixed grace interval to respond. If the grace interval also runs out while the interrupt flag is still set, the block records a reset cause and can request a system reset.

There are two reset inputs. `rst_ni` is the core-domain reset and clears everything except the reset-cause flag. `por_ni` is the power-on reset and clears that flag too. The reset-cause flag therefore survives the system reset that the watchdog itself requests, and software can read it afterwards to find out why the system restarted.

Top module: `twostage_wdt`

## Requirements
- R1: After reset the control word reads 0x00000400: clock select 1 at bits 11:10, and every other field zero. Bit 0 (restart) always reads 0. The other fields are at these positions: bit 9 freeze enable (stored only), bit 7 enable, bit 6 interrupt enable, bits 5:4 interval select, bit 3 interrupt flag, bit 2 reset flag, bit 1 reset enable.
- R2: The clock select values 0, 1, 2 and 3 produce one counting tick every 1, 256, 2048 and 65536 reference cycles. A restart clears the prescaler phase.
- R3: The timeout is 2^(BASE_EXP + 2*S) ticks, where S is the interval select value. The interrupt flag becomes visible on the clock edge of the last tick.
- R4: A write with bit 0 set reloads the full timeout for the interval written. Counting then begins only if bit 7 of that same write is 1. A restart written with bit 7 at 0 leaves the counter loaded but idle.
- R5: A write that changes bit 7 without bit 0 set pauses the count or resumes it. The count held while paused is kept exactly.
- R6: On the first expiry the interrupt flag is set and the counter reloads with GRACE_CYC ticks, then keeps counting.
- R7: `irq_o` is a level equal to the interrupt flag AND the interrupt enable bit.
- R8: An expiry while the interrupt flag is set, with reset enable set, sets the reset flag and drives `sys_rst_o` high for exactly one cycle. With reset enable clear, that expiry does neither.
- R9: Writing 1 to bit 3 or to bit 2 clears that flag. Writing 0 to either bit leaves it unchanged.
- R10: A core reset leaves the reset flag at its previous value. A power-on reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Core reset, active low, asynchronous |
| por_ni | input | 1 | Power-on reset for the reset flag, active low, asynchronous |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Current control word |
| irq_o | output | 1 | Interrupt level |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach from the ports is a second expiry. It only happens after a complete timeout followed by a complete grace interval, with the interrupt flag left uncleared in between. The bench builds the block with a small base exponent and a short grace interval. It arms the watchdog with clock select 0, and then writes in the middle of the grace interval to turn on interrupt enable while leaving the flags alone. That same sequence also shows that writing 0 to a flag does not clear it, and it places the reset pulse on a cycle the bench can predict. Then a core reset is applied while the reset flag is set, to confirm the flag is kept.

// File: rtl/twostage_wdt_pkg.sv
package twostage_wdt_pkg;
  localparam int unsigned REG_W = 32;

  typedef struct packed {
    logic [1:0] csel;
    logic       frz;
    logic       en;
    logic       ie;
    logic [1:0] ivl;
    logic       iflag;
    logic       rflag;
    logic       rst_en;
  } wdt_cfg_t;

  function automatic logic [REG_W-1:0] pack_cfg(wdt_cfg_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[11:10] = c.csel;
    r[9]     = c.frz;
    r[7]     = c.en;
    r[6]     = c.ie;
    r[5:4]   = c.ivl;
    r[3]     = c.iflag;
    r[2]     = c.rflag;
    r[1]     = c.rst_en;
    return r;
  endfunction

  function automatic logic [15:0] div_m1(logic [1:0] s);
    case (s)
      2'd0:    return 16'd0;
      2'd1:    return 16'd255;
      2'd2:    return 16'd2047;
      default: return 16'd65535;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import twostage_wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       restart_i,
  input  logic [1:0] csel_i,
  output logic       tick_o
);
  logic [15:0] pre_q;

  // >= so a smaller divider chosen mid-count still produces a tick
  assign tick_o = en_i & (pre_q >= div_m1(csel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (en_i)      pre_q <= tick_o ? '0 : pre_q + 16'd1;
  end

  p_phase_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> pre_q == '0);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned BASE_EXP  = 14,
  parameter int unsigned GRACE_CYC = 1024,
  parameter int unsigned CNT_W     = 21
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       restart_i,
  input  logic [1:0] load_ivl_i,
  output logic       expire_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] load_val(logic [1:0] ivl);
    logic [CNT_W-1:0] one;
    one = 1;
    return one << (BASE_EXP + 2 * int'(ivl));
  endfunction

  assign expire_o = en_i & tick_i & (cnt_q <= 1) & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= load_val(2'd0);
    else if (restart_i)     cnt_q <= load_val(load_ivl_i);
    else if (expire_o)      cnt_q <= CNT_W'(GRACE_CYC);
    else if (en_i & tick_i) cnt_q <= cnt_q - 1'b1;
  end

  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == load_val($past(load_ivl_i)));
  p_pause_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !restart_i) |=> $stable(cnt_q));
  p_grace_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == CNT_W'(GRACE_CYC));
endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
  import twostage_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             expire_i,
  output wdt_cfg_t         cfg_o,
  output logic             restart_o,
  output logic             rst_pulse_o
);
  wdt_cfg_t cfg_q;
  logic     rflag_q;
  logic     pulse_q;
  logic     iflag_d;
  logic     second_exp;
  logic     unused_bits;

  assign unused_bits = ^{wr_data_i[REG_W-1:12], wr_data_i[8]};
  assign restart_o   = wr_en_i & wr_data_i[0];
  assign second_exp  = expire_i & cfg_q.iflag;

  always_comb begin
    iflag_d = cfg_q.iflag;
    if (wr_en_i && wr_data_i[3]) iflag_d = 1'b0;
    if (expire_i && !cfg_q.iflag) iflag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      cfg_q.csel <= 2'd1;
      pulse_q    <= 1'b0;
    end else begin
      if (wr_en_i) begin
        cfg_q.csel   <= wr_data_i[11:10];
        cfg_q.frz    <= wr_data_i[9];
        cfg_q.en     <= wr_data_i[7];
        cfg_q.ie     <= wr_data_i[6];
        cfg_q.ivl    <= wr_data_i[5:4];
        cfg_q.rst_en <= wr_data_i[1];
      end
      cfg_q.iflag <= iflag_d;
      pulse_q     <= second_exp & cfg_q.rst_en;
    end
  end

  // reset cause lives in the power-on domain
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                          rflag_q <= 1'b0;
    else if (second_exp && cfg_q.rst_en)  rflag_q <= 1'b1;
    else if (wr_en_i && wr_data_i[2])     rflag_q <= 1'b0;
  end

  always_comb begin
    cfg_o       = cfg_q;
    cfg_o.rflag = rflag_q;
  end
  assign rst_pulse_o = pulse_q;

  p_iflag_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[3] && !expire_i) |=> !cfg_q.iflag);
  p_iflag_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_q.iflag) |-> $past(expire_i));
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import twostage_wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP  = 14,
  parameter int unsigned GRACE_CYC = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o,
  output logic        sys_rst_o
);
  localparam int unsigned GRACE_W = $clog2(GRACE_CYC + 1);
  localparam int unsigned CNT_W   = (BASE_EXP + 7 > GRACE_W) ? BASE_EXP + 7 : GRACE_W;

  wdt_cfg_t cfg;
  logic     restart, tick, expire, rst_pulse;

  wdt_csr u_csr (
    .clk_i, .rst_ni, .por_ni, .wr_en_i, .wr_data_i,
    .expire_i   (expire),
    .cfg_o      (cfg),
    .restart_o  (restart),
    .rst_pulse_o(rst_pulse)
  );

  wdt_prescale u_pre (
    .clk_i, .rst_ni,
    .en_i     (cfg.en),
    .restart_i(restart),
    .csel_i   (cfg.csel),
    .tick_o   (tick)
  );

  wdt_count #(.BASE_EXP(BASE_EXP), .GRACE_CYC(GRACE_CYC), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .en_i      (cfg.en),
    .restart_i (restart),
    .load_ivl_i(wr_data_i[5:4]),
    .expire_o  (expire)
  );

  assign rd_data_o = pack_cfg(cfg);
  assign irq_o     = cfg.iflag & cfg.ie;
  assign sys_rst_o = rst_pulse;

  p_rst_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);
  p_rst_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> rd_data_o[2]);
  p_restart_rd0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !rd_data_o[0]);
endmodule

// File: tb/twostage_wdt_bench.sv
module twostage_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B = 2;
  localparam int G = 8;
  localparam int LIMIT = 150000;

  localparam logic [31:0] RS = 32'h1, RE = 32'h2, RF = 32'h4, IFL = 32'h8;
  localparam logic [31:0] IE = 32'h40, EN = 32'h80;

  logic clk = 0, rst_n = 0, por_n = 0, wr_en = 0;
  logic [31:0] wr_data = 0, rd;
  logic irq, srst;
  int checks = 0, fails = 0, cyc = 0;

  twostage_wdt #(.BASE_EXP(B), .GRACE_CYC(G)) u_twostage_wdt (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd), .irq_o(irq), .sys_rst_o(srst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ivl(int s); return 32'(s) << 4; endfunction
  function automatic logic [31:0] cs(int s);  return 32'(s) << 10; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      fails++; checks++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, LIMIT);
      report();
    end
  end

  task automatic t_reset;
    chk("R1 reset word", rd, 32'h400);
    chk("R7 irq at reset", {31'b0, irq}, 0);
    chk("R8 rst at reset", {31'b0, srst}, 0);
  endtask

  task automatic t_timeout(int s);
    int n = 4 << (2 * s);
    wr(RS | EN | ivl(s));
    chk("R1 restart reads 0", {31'b0, rd[0]}, 0);
    repeat (n - 1) @(negedge clk);
    chk("R3 no flag before timeout", {31'b0, rd[3]}, 0);
    @(negedge clk);
    chk("R3 flag at timeout", {31'b0, rd[3]}, 1);
    wr(IFL);
    chk("R9 w1c clears iflag", rd, 32'h0);
  endtask

  task automatic t_prescale(int c);
    int d = (c == 1) ? 256 : 2048;
    wr(RS | EN | cs(c));
    repeat (4 * d - 1) @(negedge clk);
    chk("R2 prescaled no flag yet", {31'b0, rd[3]}, 0);
    @(negedge clk);
    chk("R2 prescaled flag", {31'b0, rd[3]}, 1);
    wr(IFL);
  endtask

  task automatic t_restart_noen;
    wr(RS);
    repeat (20) @(negedge clk);
    chk("R4 restart without enable idle", {31'b0, rd[3]}, 0);
    wr(EN);
    repeat (3) @(negedge clk);
    chk("R4 loaded count not yet out", {31'b0, rd[3]}, 0);
    @(negedge clk);
    chk("R4 loaded count expires", {31'b0, rd[3]}, 1);
    wr(IFL);
  endtask

  task automatic t_pause;
    wr(RS | EN | ivl(1));
    @(negedge clk);
    wr(ivl(1));
    repeat (20) @(negedge clk);
    chk("R5 paused no flag", {31'b0, rd[3]}, 0);
    wr(EN | ivl(1));
    repeat (13) @(negedge clk);
    chk("R5 resumed count held", {31'b0, rd[3]}, 0);
    @(negedge clk);
    chk("R5 resumed expiry", {31'b0, rd[3]}, 1);
    wr(IFL);
  endtask

  task automatic t_second_stage;
    wr(RS | EN | RE);
    repeat (4) @(negedge clk);
    chk("R6 first expiry flag", {31'b0, rd[3]}, 1);
    chk("R7 irq masked", {31'b0, irq}, 0);
    wr(EN | RE | IE);
    chk("R7 irq level", {31'b0, irq}, 1);
    chk("R9 write 0 keeps iflag", {31'b0, rd[3]}, 1);
    repeat (6) @(negedge clk);
    chk("R6 grace not over", {31'b0, srst}, 0);
    @(negedge clk);
    chk("R8 reset pulse", {31'b0, srst}, 1);
    chk("R8 reset flag", {31'b0, rd[2]}, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, srst}, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 core reset keeps rflag", rd, 32'h404);
    chk("R7 irq cleared by reset", {31'b0, irq}, 0);
    wr(RF | cs(1));
    chk("R9 w1c clears rflag", rd, 32'h400);
  endtask

  task automatic t_no_rst_en;
    int pulses = 0;
    wr(RS | EN);
    repeat (4) @(negedge clk);
    chk("R6 flag without rst enable", {31'b0, rd[3]}, 1);
    repeat (12) begin
      @(negedge clk);
      if (srst) pulses++;
    end
    chk("R8 no pulse when disabled", 32'(pulses), 0);
    chk("R8 no rflag when disabled", {31'b0, rd[2]}, 0);
    wr(IFL);
  endtask

  task automatic t_por;
    wr(RS | EN | RE);
    repeat (4 + G) @(negedge clk);
    chk("R8 rflag before por", {31'b0, rd[2]}, 1);
    por_n = 0; rst_n = 0;
    @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    chk("R10 por clears rflag", rd, 32'h400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    t_reset();
    wr(32'h0);
    for (int s = 0; s < 3; s++) t_timeout(s);
    t_prescale(1);
    t_prescale(2);
    wr(32'h0);
    t_restart_noen();
    t_pause();
    t_second_stage();
    wr(32'h0);
    t_no_rst_en();
    t_por();
    report();
  end
endmodule